// File: doc/BRIEF.md
# Interleaved ADC Capture with Parity Check

This block sits at the receiving end of a parallel converter link that carries four receive channels time-multiplexed on one 12-bit bus, one sample per clock while a valid strobe is high. Each sample arrives with a thirteenth line carrying a parity bit. The block checks that bit as the sample passes, tags the sample with the channel it belongs to, and hands it on one cycle later. Nothing is dropped or buffered.

Two sync lines frame the stream. The group sync marks the sample that belongs to channel 0. The block holds an internal channel rotation and checks each group sync against it. A group sync that arrives early or late is counted as a framing error, and the rotation realigns to it. The chirp sync marks the first sample of a chirp and restarts a per-chirp sample index.

Samples that fail parity are still passed downstream, but their error flag is raised. Two saturating 16-bit counters record parity and framing errors. A clear input resets both counters.

Top module: `adc_ilv_capture`

## Requirements
- R1: While reset is low, out_vld, out_perr, out_ferr, out_ch, out_idx, out_data and both error counters are 0. The first sample after reset is expected to be channel 0.
- R2: The outputs are registered with one cycle of latency. out_vld in a cycle equals in_vld in the cycle before. A valid sample's data bits appear unchanged on out_data.
- R3: Without a group sync, valid samples are tagged with channels 0, 1, 2, 3, 0, … in arrival order. The channel number wraps after 3.
- R4: A valid sample with sync_grp high is tagged channel 0, and the rotation continues from it. out_ferr is raised for that sample only if the previous valid sample was not channel 3. After reset, the rotation counts as having just finished channel 3.
- R5: Parity is even over in_data and in_par together. When par_en is 1 and those 13 bits hold an odd number of ones, out_perr is raised with the sample. The sample is still forwarded.
- R6: When par_en is 0, out_perr stays 0 and perr_cnt does not change, whatever the parity bit is.
- R7: A valid sample with sync_chirp high gets out_idx 0. Each following valid sample gets the previous index plus one, wrapping at 2^10.
- R8: perr_cnt and ferr_cnt each add one per flagged sample, with the new value seen in the same cycle as the flag. They hold at 65535 instead of wrapping.
- R9: When cnt_clr is high at a clock edge, both counters read 0 after that edge. Clear wins over an increment in the same cycle.
- R10: Cycles with in_vld low leave the channel rotation, the chirp index and both counters unchanged. This holds whatever the data, parity and sync inputs are. The flags stay 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_en | input | 1 | Enables the parity check |
| cnt_clr | input | 1 | Clears both error counters |
| in_vld | input | 1 | A sample is present this cycle |
| in_data | input | 12 | Sample bits |
| in_par | input | 1 | Parity bit from the thirteenth line |
| sync_grp | input | 1 | Marks the channel-0 sample of a group |
| sync_chirp | input | 1 | Marks the first sample of a chirp |
| out_vld | output | 1 | Output sample valid |
| out_data | output | 12 | Forwarded sample bits |
| out_ch | output | 2 | Channel of the forwarded sample |
| out_idx | output | 10 | Sample index within the chirp |
| out_perr | output | 1 | Forwarded sample failed parity |
| out_ferr | output | 1 | Group sync was out of step on this sample |
| perr_cnt | output | 16 | Saturating parity error count |
| ferr_cnt | output | 16 | Saturating framing error count |

## Verification
The channel rotation is the only state that can go wrong without being seen. If it slips, every later out_ch is wrong starting with the next valid sample. The next group sync then shows the slip as an unexpected out_ferr and a ferr_cnt step. A wrong chirp index shows on out_idx with the next valid sample, and lasts until the next chirp sync. Counter faults show at once, and around 65535 they show only after tens of thousands of flagged samples. For that reason the bench drives the counters all the way to saturation instead of sampling near it.

// File: rtl/adc_ilv_capture.sv
module adc_ilv_capture #(
  parameter int DW   = 12,
  parameter int NCH  = 4,
  parameter int CNTW = 16,
  parameter int IDXW = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   par_en,
  input  logic                   cnt_clr,
  input  logic                   in_vld,
  input  logic [DW-1:0]          in_data,
  input  logic                   in_par,
  input  logic                   sync_grp,
  input  logic                   sync_chirp,
  output logic                   out_vld,
  output logic [DW-1:0]          out_data,
  output logic [$clog2(NCH)-1:0] out_ch,
  output logic [IDXW-1:0]        out_idx,
  output logic                   out_perr,
  output logic                   out_ferr,
  output logic [CNTW-1:0]        perr_cnt,
  output logic [CNTW-1:0]        ferr_cnt
);
  localparam int CHW = $clog2(NCH);
  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);
  localparam logic [CNTW-1:0] CNT_MAX = '1;

  logic [CHW-1:0]  nxt_ch;
  logic [IDXW-1:0] nxt_idx;
  logic [CHW-1:0]  cur_ch;
  logic [IDXW-1:0] cur_idx;
  logic            cur_perr, cur_ferr;

  assign cur_ch   = sync_grp ? '0 : nxt_ch;
  assign cur_ferr = sync_grp && (nxt_ch != '0);
  assign cur_perr = par_en && (^{in_data, in_par});
  assign cur_idx  = sync_chirp ? '0 : nxt_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
      out_ch   <= '0;
      out_idx  <= '0;
      out_perr <= 1'b0;
      out_ferr <= 1'b0;
      nxt_ch   <= '0;
      nxt_idx  <= '0;
    end else begin
      out_vld  <= in_vld;
      out_perr <= in_vld && cur_perr;
      out_ferr <= in_vld && cur_ferr;
      if (in_vld) begin
        out_data <= in_data;
        out_ch   <= cur_ch;
        out_idx  <= cur_idx;
        nxt_ch   <= (cur_ch == LAST_CH) ? '0 : cur_ch + CHW'(1);
        nxt_idx  <= cur_idx + IDXW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cnt_clr) begin
      perr_cnt <= '0;
      ferr_cnt <= '0;
    end else begin
      if (in_vld && cur_perr && perr_cnt != CNT_MAX) perr_cnt <= perr_cnt + CNTW'(1);
      if (in_vld && cur_ferr && ferr_cnt != CNT_MAX) ferr_cnt <= ferr_cnt + CNTW'(1);
    end
  end

  assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_vld == $past(in_vld));
  assert_rotation_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && !sync_grp && out_vld |=>
      out_ch == (($past(out_ch) == LAST_CH) ? '0 : $past(out_ch) + CHW'(1)));
  assert_sync_ch0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && sync_grp |=> out_ch == '0);
  assert_par_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !par_en && !cnt_clr |=> !out_perr && $stable(perr_cnt));
  assert_chirp_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && sync_chirp |=> out_idx == '0);
  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    perr_cnt == CNT_MAX && !cnt_clr |=> perr_cnt == CNT_MAX);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> perr_cnt == '0 && ferr_cnt == '0);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld && !cnt_clr |=> !out_perr && !out_ferr && $stable(perr_cnt) && $stable(ferr_cnt));
endmodule

// File: tb/adc_ilv_capture_tb_top.sv
module adc_ilv_capture_tb_top;
  localparam int NCH = 4, IDXW = 10, CMAX = 65535;

  logic clk = 1'b0, rst_n = 1'b0, par_en = 1'b0, cnt_clr = 1'b0, in_vld = 1'b0;
  logic [11:0] in_data = '0;
  logic in_par = 1'b0, sync_grp = 1'b0, sync_chirp = 1'b0;
  logic out_vld, out_perr, out_ferr;
  logic [11:0] out_data;
  logic [1:0] out_ch;
  logic [9:0] out_idx;
  logic [15:0] perr_cnt, ferr_cnt;

  adc_ilv_capture dut_i (
    .clk(clk), .rst_n(rst_n), .par_en(par_en), .cnt_clr(cnt_clr), .in_vld(in_vld),
    .in_data(in_data), .in_par(in_par), .sync_grp(sync_grp), .sync_chirp(sync_chirp),
    .out_vld(out_vld), .out_data(out_data), .out_ch(out_ch), .out_idx(out_idx),
    .out_perr(out_perr), .out_ferr(out_ferr), .perr_cnt(perr_cnt), .ferr_cnt(ferr_cnt));

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int m_nxt = 0, m_idx = 0, m_pc = 0, m_fc = 0;

  function automatic bit parity_bad(logic [11:0] d, logic p);
    return ^{d, p};
  endfunction

  function automatic int sat_inc(int c, bit hit);
    return (hit && c < CMAX) ? c + 1 : c;
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic cyc(string req, bit v, logic [11:0] d, bit p, bit sg, bit sc, bit en, bit clr);
    int e_ch, e_idx;
    bit e_f, e_p;
    @(negedge clk);
    in_vld = v; in_data = d; in_par = p; sync_grp = sg; sync_chirp = sc; par_en = en; cnt_clr = clr;
    e_ch  = sg ? 0 : m_nxt;
    e_f   = v && sg && (m_nxt != 0);
    e_p   = v && en && parity_bad(d, p);
    e_idx = sc ? 0 : m_idx;
    if (v) begin
      m_nxt = (e_ch + 1) % NCH;
      m_idx = (e_idx + 1) % (1 << IDXW);
    end
    m_pc = clr ? 0 : sat_inc(m_pc, e_p);
    m_fc = clr ? 0 : sat_inc(m_fc, e_f);
    @(posedge clk); #1;
    chk(req, "out_vld", int'(out_vld), int'(v));
    if (v) begin
      chk(req, "out_data", int'(out_data), int'(d));
      chk(req, "out_ch", int'(out_ch), e_ch);
      chk(req, "out_idx", int'(out_idx), e_idx);
    end
    chk(req, "out_perr", int'(out_perr), int'(e_p));
    chk(req, "out_ferr", int'(out_ferr), int'(e_f));
    chk(req, "perr_cnt", int'(perr_cnt), m_pc);
    chk(req, "ferr_cnt", int'(ferr_cnt), m_fc);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [11:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "out_vld", int'(out_vld), 0);
    chk("R1", "out_perr", int'(out_perr), 0);
    chk("R1", "out_ferr", int'(out_ferr), 0);
    chk("R1", "out_ch", int'(out_ch), 0);
    chk("R1", "out_idx", int'(out_idx), 0);
    chk("R1", "out_data", int'(out_data), 0);
    chk("R1", "perr_cnt", int'(perr_cnt), 0);
    chk("R1", "ferr_cnt", int'(ferr_cnt), 0);
    rst_n = 1'b1;

    cyc("R4", 1, 12'h123, 1'b0, 1, 1, 1, 0);
    cyc("R3", 1, 12'hABC, 1'b0, 0, 0, 1, 0);
    cyc("R3", 1, 12'h001, 1'b1, 0, 0, 1, 0);
    cyc("R3", 1, 12'hFFF, 1'b0, 0, 0, 1, 0);
    cyc("R10", 0, 12'h001, 1'b0, 1, 1, 1, 0);
    cyc("R3", 1, 12'h555, 1'b0, 0, 0, 1, 0);
    cyc("R2", 1, 12'hA5A, 1'b0, 0, 0, 1, 0);
    cyc("R4", 1, 12'h0F0, 1'b0, 1, 0, 1, 0);
    cyc("R4", 1, 12'h00F, 1'b0, 0, 0, 1, 0);
    cyc("R5", 1, 12'h007, 1'b0, 0, 0, 1, 0);
    cyc("R5", 1, 12'h007, 1'b1, 0, 0, 1, 0);
    cyc("R6", 1, 12'h007, 1'b0, 0, 0, 0, 0);
    cyc("R7", 1, 12'h111, 1'b1, 0, 1, 1, 0);
    cyc("R7", 1, 12'h222, 1'b0, 0, 0, 1, 0);
    cyc("R10", 0, 12'h001, 1'b0, 1, 0, 1, 0);
    cyc("R9", 1, 12'h001, 1'b0, 1, 0, 1, 1);

    for (int i = 0; i < 3000; i++) begin
      bit v, sg, p;
      v  = ($urandom % 10) < 8;
      rd = 12'($urandom);
      p  = ^rd;
      if (($urandom % 10) == 0) p = ~p;
      sg = (m_nxt == 0) ? (($urandom % 8) != 0) : (($urandom % 20) == 0);
      cyc("R3", v, rd, p, sg, ($urandom % 25) == 0, ($urandom % 16) != 0, ($urandom % 100) == 0);
    end

    for (int i = 0; i < CMAX + 4; i++)
      cyc("R8", 1, 12'h001, 1'b0, 1, 0, 1, 0);
    chk("R8", "perr_cnt at limit", int'(perr_cnt), CMAX);
    cyc("R9", 1, 12'h001, 1'b0, 1, 0, 1, 1);
    cyc("R9", 1, 12'h003, 1'b0, 0, 0, 1, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
  end
endmodule